// File: doc/BRIEF.md
# Per-Pipeline Latency Monitor

The monitor times packets through three independent processing pipelines. Each pipeline reports an ingress pulse when a packet enters and an egress pulse when a packet leaves, and each pulse carries the packet's tag. On ingress the block stores the tag together with a free-running 16-bit cycle stamp in that pipeline's own queue. On egress it takes the oldest stored entry of that pipeline. When the tags agree, the difference between the current stamp and the stored one becomes that pipeline's most recent latency.

A decision interval has no fixed length. It closes when the slowest pipeline that still has work has finished its quota of five packets. At that point the block raises a one-cycle strobe and presents a snapshot of every pipeline's latency to a downstream reconfiguration controller. A pipeline that finished nothing during the interval keeps its older value in the snapshot and is flagged stale. The snapshot stays unchanged until the next strobe.

Top module: `pipe_latency_monitor`

## Requirements
- R1: A packet whose ingress pulse is sampled on clock edge t and whose matching egress pulse is sampled on edge t+k is measured as k cycles.
- R2: Latency is the 16-bit stamp difference taken modulo 65536, so a packet held 70000 cycles reads 4464.
- R3: Each pipeline matches egress to ingress in arrival order. An egress whose tag differs from the oldest queued tag removes that entry, but it neither updates the latency nor counts as a completion.
- R4: Each pipeline queues at most eight packets. An ingress while eight are queued is dropped, and an egress with nothing queued is ignored.
- R5: An interval closes when at least one pipeline has five matched completions and every other pipeline has either five completions or an empty queue. The strobe is high in the cycle after the edge that sampled the closing egress.
- R6: The strobe lasts exactly one cycle, and the snapshot holds its value between strobes.
- R7: Completion counts are cleared on the same edge that latches the snapshot. A matched egress sampled on that edge counts as the first completion of the new interval.
- R8: In the snapshot, pipeline p occupies latency bits [16p+15:16p] and stale bit p. A pipeline with no matched completion during the interval repeats its previous latency with its stale bit set to 1.
- R9: After reset the strobe is 0, all snapshot latencies are 0 and all stale bits are 1.
- R10: A pipeline accepts ingress pulses on consecutive cycles, which is faster than the required rate of one packet every ten cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ing_valid | input | 3 | Per-pipeline ingress pulse, bit p for pipeline p |
| ing_tag | input | 24 | Per-pipeline ingress tag, 8 bits each, pipeline p at [8p+7:8p] |
| egr_valid | input | 3 | Per-pipeline egress pulse |
| egr_tag | input | 24 | Per-pipeline egress tag, same layout as ing_tag |
| snap_valid | output | 1 | One-cycle interval-end strobe |
| snap_lat | output | 48 | Latency snapshot, 16 bits per pipeline |
| snap_stale | output | 3 | Per-pipeline stale flag in the snapshot |

## Verification
A latency is computed on the edge that samples the egress pulse. It becomes visible only through the next snapshot, and the snapshot is latched one edge after the closing egress. The bench drives inputs on the falling edge and steps one cycle at a time. In every step it samples the strobe on the falling edge and counts pulses, so each check compares the strobe count and the snapshot at exactly the cycle where they are due. Stimulus that must change nothing, such as a dropped ingress, an empty egress or a tag mismatch, is judged by whether the strobe comes one packet early, one packet late or on time.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int unsigned PLM_PIPES = 3;
  localparam int unsigned PLM_TAG_W = 8;
  localparam int unsigned PLM_TS_W  = 16;

  typedef enum logic [1:0] {
    EGR_NONE  = 2'd0,
    EGR_MATCH = 2'd1,
    EGR_MISS  = 2'd2
  } plm_egr_e;
endpackage

// File: rtl/plm_stamp_fifo.sv
module plm_stamp_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] fill;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + CNTW'(1);
        2'b01:   fill <= fill - CNTW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (fill == '0);
  assign full  = (fill == CNTW'(DEPTH));
endmodule

// File: rtl/plm_lane.sv
module plm_lane
  import plm_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int TS_W  = 16,
  parameter int DEPTH = 8,
  parameter int QUOTA = 5,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  ts_now,
  input  logic             in_v,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             out_v,
  input  logic [TAG_W-1:0] out_tag,
  input  logic             clear,
  output logic [TS_W-1:0]  last_lat,
  output logic             fresh,
  output logic [CW-1:0]    done_cnt,
  output logic             idle
);
  localparam int EW = TAG_W + TS_W;

  logic          push, pop, q_empty, q_full;
  logic [EW-1:0] head;
  logic [TAG_W-1:0] head_tag;
  logic [TS_W-1:0]  head_ts;
  plm_egr_e      act;

  assign push = in_v & ~q_full;
  assign pop  = out_v & ~q_empty;

  plm_stamp_fifo #(.W(EW), .DEPTH(DEPTH)) i_queue (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .din  ({in_tag, ts_now}),
    .pop  (pop),
    .dout (head),
    .empty(q_empty),
    .full (q_full)
  );

  assign head_tag = head[TS_W +: TAG_W];
  assign head_ts  = head[TS_W-1:0];

  always_comb begin
    if (!pop)                  act = EGR_NONE;
    else if (head_tag == out_tag) act = EGR_MATCH;
    else                       act = EGR_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_lat <= '0;
      fresh    <= 1'b0;
      done_cnt <= '0;
    end else begin
      if (act == EGR_MATCH) last_lat <= ts_now - head_ts;
      if (clear) begin
        fresh    <= (act == EGR_MATCH);
        done_cnt <= (act == EGR_MATCH) ? CW'(1) : '0;
      end else if (act == EGR_MATCH) begin
        fresh <= 1'b1;
        if (done_cnt != CW'(QUOTA)) done_cnt <= done_cnt + CW'(1);
      end
    end
  end

  assign idle = q_empty;
endmodule

// File: rtl/plm_interval.sv
module plm_interval #(
  parameter int NP    = 3,
  parameter int TS_W  = 16,
  parameter int CW    = 3,
  parameter int QUOTA = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NP*CW-1:0]  done_flat,
  input  logic [NP-1:0]     idle,
  input  logic [NP*TS_W-1:0] lat_flat,
  input  logic [NP-1:0]     fresh,
  output logic              fire,
  output logic              snap_valid,
  output logic [NP*TS_W-1:0] snap_lat,
  output logic [NP-1:0]     snap_stale
);
  logic [NP-1:0] at_quota, settled;

  for (genvar p = 0; p < NP; p++) begin : g_lane_state
    assign at_quota[p] = (done_flat[p*CW +: CW] == CW'(QUOTA));
    assign settled[p]  = at_quota[p] | idle[p];
  end

  assign fire = (|at_quota) & (&settled);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_valid <= 1'b0;
      snap_lat   <= '0;
      snap_stale <= '1;
    end else begin
      snap_valid <= fire;
      if (fire) begin
        snap_lat   <= lat_flat;
        snap_stale <= ~fresh;
      end
    end
  end
endmodule

// File: rtl/pipe_latency_monitor.sv
module pipe_latency_monitor #(
  parameter int NP    = 3,
  parameter int TAG_W = 8,
  parameter int TS_W  = 16,
  parameter int DEPTH = 8,
  parameter int QUOTA = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NP-1:0]       ing_valid,
  input  logic [NP*TAG_W-1:0] ing_tag,
  input  logic [NP-1:0]       egr_valid,
  input  logic [NP*TAG_W-1:0] egr_tag,
  output logic                snap_valid,
  output logic [NP*TS_W-1:0]  snap_lat,
  output logic [NP-1:0]       snap_stale
);
  localparam int CW = $clog2(QUOTA + 1);

  logic [TS_W-1:0]    ts_now;
  logic [NP*CW-1:0]   done_flat;
  logic [NP*TS_W-1:0] lat_flat;
  logic [NP-1:0]      lane_idle, lane_fresh;
  logic               iv_fire;

  always_ff @(posedge clk) begin
    if (rst) ts_now <= '0;
    else     ts_now <= ts_now + TS_W'(1);
  end

  for (genvar p = 0; p < NP; p++) begin : g_lane
    plm_lane #(
      .TAG_W(TAG_W), .TS_W(TS_W), .DEPTH(DEPTH), .QUOTA(QUOTA), .CW(CW)
    ) i_lane (
      .clk     (clk),
      .rst     (rst),
      .ts_now  (ts_now),
      .in_v    (ing_valid[p]),
      .in_tag  (ing_tag[p*TAG_W +: TAG_W]),
      .out_v   (egr_valid[p]),
      .out_tag (egr_tag[p*TAG_W +: TAG_W]),
      .clear   (iv_fire),
      .last_lat(lat_flat[p*TS_W +: TS_W]),
      .fresh   (lane_fresh[p]),
      .done_cnt(done_flat[p*CW +: CW]),
      .idle    (lane_idle[p])
    );
  end

  plm_interval #(.NP(NP), .TS_W(TS_W), .CW(CW), .QUOTA(QUOTA)) i_interval (
    .clk       (clk),
    .rst       (rst),
    .done_flat (done_flat),
    .idle      (lane_idle),
    .lat_flat  (lat_flat),
    .fresh     (lane_fresh),
    .fire      (iv_fire),
    .snap_valid(snap_valid),
    .snap_lat  (snap_lat),
    .snap_stale(snap_stale)
  );
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int NP    = 3,
  parameter int TS_W  = 16,
  parameter int CW    = 3,
  parameter int QUOTA = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               fire,
  input logic [NP*CW-1:0]   done_flat,
  input logic               snap_valid,
  input logic [NP*TS_W-1:0] snap_lat,
  input logic [NP-1:0]      snap_stale
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) snap_valid |=> !snap_valid); // R6
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst) !snap_valid |-> ($stable(snap_lat) && $stable(snap_stale))); // R6
  AST_SNAP_FRESH: assert property (@(posedge clk) disable iff (rst) snap_valid |-> ($countones(snap_stale) < NP)); // R8

  for (genvar p = 0; p < NP; p++) begin : g_chk
    AST_DONE_LIMIT: assert property (@(posedge clk) disable iff (rst) done_flat[p*CW +: CW] <= CW'(QUOTA)); // R5
    AST_CLEAR_COUNT: assert property (@(posedge clk) disable iff (rst) fire |=> (done_flat[p*CW +: CW] <= CW'(1))); // R7
  end
endmodule

bind pipe_latency_monitor plm_checker #(.NP(NP), .TS_W(TS_W), .CW(CW), .QUOTA(QUOTA)) i_plm_checker (
  .clk       (clk),
  .rst       (rst),
  .fire      (iv_fire),
  .done_flat (done_flat),
  .snap_valid(snap_valid),
  .snap_lat  (snap_lat),
  .snap_stale(snap_stale)
);

// File: tb/test_pipe_latency_monitor.sv
module test_pipe_latency_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ing_valid = '0;
  logic [23:0] ing_tag = '0;
  logic [2:0]  egr_valid = '0;
  logic [23:0] egr_tag = '0;
  logic        snap_valid;
  logic [47:0] snap_lat;
  logic [2:0]  snap_stale;

  int checks = 0;
  int errors = 0;
  int strobes = 0;

  always #4 clk = ~clk;

  pipe_latency_monitor i_pipe_latency_monitor (
    .clk(clk), .rst(rst),
    .ing_valid(ing_valid), .ing_tag(ing_tag),
    .egr_valid(egr_valid), .egr_tag(egr_tag),
    .snap_valid(snap_valid), .snap_lat(snap_lat), .snap_stale(snap_stale)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // one clock cycle; inputs are applied at the falling edge
  task automatic step(input logic [2:0] iv, input logic [7:0] itag,
                      input logic [2:0] ev, input logic [7:0] etag);
    ing_valid = iv; ing_tag = {3{itag}};
    egr_valid = ev; egr_tag = {3{etag}};
    @(posedge clk);
    @(negedge clk);
    ing_valid = '0; egr_valid = '0;
    if (snap_valid) strobes++;
  endtask

  // one packet per enabled pipeline, pipeline p leaving after k_p cycles
  task automatic round(input logic [2:0] mask, input logic [7:0] tag,
                       input int k0, input int k1, input int k2);
    int kmax;
    kmax = (k0 > k1) ? k0 : k1;
    kmax = (k2 > kmax) ? k2 : kmax;
    step(mask, tag, 3'b000, 8'h00);
    for (int c = 1; c <= kmax; c++) begin
      step(3'b000, 8'h00, mask & {(k2 == c), (k1 == c), (k0 == c)}, tag);
    end
  endtask

  task automatic t_reset();
    check(32'(snap_valid), 0, "R9 strobe after reset");
    check(32'(snap_stale), 7, "R9 stale after reset");
    check(snap_lat[31:0], 0, "R9 latency after reset");
  endtask

  task automatic t_basic();
    int s0 = strobes;
    for (int n = 0; n < 5; n++) round(3'b111, 8'(n), 4 + n, 7 + n, 10 + n);
    check(32'(strobes - s0), 0, "R5 no strobe before slowest finishes");
    step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(strobes - s0), 1, "R5 strobe one cycle after closing egress");
    check(32'(snap_lat[15:0]), 8, "R1 pipe0 latency");
    check(32'(snap_lat[31:16]), 11, "R1 pipe1 latency");
    check(32'(snap_lat[47:32]), 14, "R1 pipe2 latency");
    check(32'(snap_stale), 0, "R8 all fresh");
    step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(snap_valid), 0, "R6 strobe is one cycle");
    for (int i = 0; i < 4; i++) step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(snap_lat[47:32]), 14, "R6 snapshot held");
    check(32'(strobes - s0), 1, "R6 no extra strobe");
  endtask

  task automatic t_stale();
    int s0 = strobes;
    for (int n = 0; n < 5; n++) round(3'b011, 8'(8'h20 + n), 3 + n, 6 + n, 0);
    step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(strobes - s0), 1, "R5 idle pipe does not hold interval");
    check(32'(snap_lat[15:0]), 7, "R1 pipe0 latency");
    check(32'(snap_lat[31:16]), 10, "R1 pipe1 latency");
    check(32'(snap_lat[47:32]), 14, "R8 idle pipe keeps old latency");
    check(32'(snap_stale), 4, "R8 idle pipe flagged stale");
  endtask

  task automatic t_depth();
    int s0 = strobes;
    for (int i = 0; i < 9; i++) step(3'b010, 8'(i), 3'b000, 8'h00);
    for (int j = 0; j < 8; j++) step(3'b000, 8'h00, 3'b010, 8'(j));
    check(32'(strobes - s0), 1, "R10 back-to-back ingress matched in order");
    check(32'(snap_lat[31:16]), 9, "R3 in-order latency");
    check(32'(snap_stale), 5, "R8 other pipes stale");
    step(3'b000, 8'h00, 3'b010, 8'h08);
    step(3'b010, 8'h09, 3'b000, 8'h00);
    for (int i = 0; i < 5; i++) step(3'b000, 8'h00, 3'b000, 8'h00);
    step(3'b000, 8'h00, 3'b010, 8'h09);
    step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(strobes - s0), 1, "R4 ninth ingress dropped, empty egress ignored");
    round(3'b010, 8'h0a, 0, 7, 0);
    step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(strobes - s0), 2, "R7 egress on clear edge counted in new interval");
    check(32'(snap_lat[31:16]), 7, "R7 latency of closing packet");
  endtask

  task automatic t_mismatch();
    int s0 = strobes;
    step(3'b001, 8'h40, 3'b000, 8'h00);
    step(3'b000, 8'h00, 3'b001, 8'h41);
    for (int n = 0; n < 4; n++) round(3'b001, 8'(8'h50 + n), 5, 0, 0);
    step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(strobes - s0), 0, "R3 mismatched egress not counted");
    round(3'b001, 8'h58, 6, 0, 0);
    step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(strobes - s0), 1, "R3 queue realigned after mismatch");
    check(32'(snap_lat[15:0]), 6, "R3 latency after mismatch");
    check(32'(snap_stale), 6, "R8 pipes 1 and 2 stale");
  endtask

  task automatic t_wrap();
    int s0 = strobes;
    for (int n = 0; n < 4; n++) round(3'b100, 8'(8'h70 + n), 0, 0, 2);
    round(3'b100, 8'h7f, 0, 0, 70000);
    step(3'b000, 8'h00, 3'b000, 8'h00);
    check(32'(strobes - s0), 1, "R2 strobe after long packet");
    check(32'(snap_lat[47:32]), 4464, "R2 latency modulo 65536");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_stale();
    t_depth();
    t_mismatch();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule